// File: doc/BRIEF.md
# MSI Snooping Line Controller

This block manages a small direct-mapped, write-back cache that is coherent with its peers on an atomic shared bus. Each line holds one tag, one data word and one of three coherence states: Invalid, Shared (a clean copy that other caches may also hold) or Modified (the only copy, owned by this cache and newer than memory). Processor reads and writes either complete locally or cause one bus transaction after the arbiter grants the bus. A dirty victim is written back before the new line is filled.

The controller also watches the transactions that other caches put on the bus. A snooped read of a line it owns makes it supply the data as a flush and keep a shared copy. A snooped request for ownership of a line it holds makes it give the line up, and it flushes first if the line is dirty. A write that is waiting to upgrade a shared copy and loses that copy to a peer's invalidation is turned into a full read-for-ownership.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and bus_req, cpu_done and flush_valid are low.
- R2: A read whose line is absent issues bus command RD (code 0) for the requested address, stores bus_rdata, and raises cpu_done with that word on cpu_rdata in the cycle after the grant. The line then becomes Shared.
- R3: A read that hits a Shared or Modified line completes with cpu_done in the cycle after the request, and it makes no bus request.
- R4: A write whose line is absent issues bus command RDX (code 1) and leaves the line Modified, holding the written word.
- R5: A write to a Shared line issues bus command UPG (code 2) and leaves the line Modified, holding the written word.
- R6: A write to a Modified line completes in the cycle after the request without any bus request, and cpu_done is a one-cycle pulse.
- R7: A snooped RD (snp_cmd 0) that hits a Modified line raises flush_valid in the same cycle with the line's word, and the line becomes Shared. A later snooped RD does not flush, and a later local write issues UPG.
- R8: A snooped RDX (snp_cmd 1) that hits a Modified line flushes its word and the line becomes Invalid, so a later local read issues RD.
- R9: A snooped RDX or UPG (snp_cmd 2) that hits a Shared line invalidates it without a flush. A snooped RD that hits a Shared line changes nothing, so a later read still hits.
- R10: A miss whose index holds a Modified line with another tag first issues WB (code 3), with the victim's address on bus_addr and its word on bus_wdata, and then the fill. A victim that is only Shared is dropped without a bus transaction.
- R11: A pending upgrade whose Shared line is invalidated by a snoop before the grant is issued as RDX instead.
- R12: A write is applied to the line at its grant edge, so the next snooped read of that line flushes the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_stall | output | 1 | Request is still outstanding |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted; the transaction happens in this cycle |
| bus_cmd | output | 2 | 0 RD, 1 RDX, 2 UPG, 3 WB |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data, valid in the grant cycle |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | This cache supplies the dirty word |
| flush_data | output | DATA_W | Flushed word |

## Verification
A hit raises cpu_done one cycle after the request is driven. A miss shows its bus transaction in the cycle in which bus_req and bus_gnt are both high, and cpu_done follows one cycle after that grant. A writeback takes one grant cycle ahead of the fill, which moves the done pulse one cycle later. A flush appears combinationally in the same cycle as the snoop that causes it. The bench queues the expected bus, flush and done events in order and compares each one at the falling edge of the cycle in which it is due, so any event that is extra or missing breaks the sequence.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  logic [1:0]        st [LINES];
  logic [TAG_W-1:0]  tg [LINES];
  logic [DATA_W-1:0] dt [LINES];
  logic              busy, done_q;
  logic [DATA_W-1:0] rdata_q;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  logic c_match, c_valid, victim_dirty, hit, accept, gnt, s_hit;

  assign c_idx        = cpu_addr[IDX_W-1:0];
  assign c_tag        = cpu_addr[ADDR_W-1:IDX_W];
  assign c_match      = tg[c_idx] == c_tag;
  assign c_valid      = c_match && st[c_idx] != ST_I;
  assign victim_dirty = !c_match && st[c_idx] == ST_M;
  assign hit          = c_valid && (!cpu_we || st[c_idx] == ST_M);
  assign accept       = cpu_req && !busy && !done_q && !snp_valid;
  assign gnt          = busy && bus_gnt;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign s_hit = tg[s_idx] == s_tag && st[s_idx] != ST_I;

  assign bus_req   = busy;
  assign bus_cmd   = victim_dirty ? C_WB : (cpu_we ? (c_valid ? C_UPG : C_RDX) : C_RD);
  assign bus_addr  = victim_dirty ? {tg[c_idx], c_idx} : cpu_addr;
  assign bus_wdata = dt[c_idx];

  assign flush_valid = snp_valid && s_hit && st[s_idx] == ST_M &&
                       (snp_cmd == C_RD || snp_cmd == C_RDX);
  assign flush_data  = dt[s_idx];

  assign cpu_stall = cpu_req && !done_q;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= ST_I;
        tg[i] <= '0;
        dt[i] <= '0;
      end
      busy    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (snp_valid && s_hit && !gnt) begin
        case (snp_cmd)
          C_RD:    if (st[s_idx] == ST_M) st[s_idx] <= ST_S;
          C_RDX:   st[s_idx] <= ST_I;
          C_UPG:   st[s_idx] <= ST_I;
          default: ;
        endcase
      end
      if (accept) begin
        if (hit) begin
          done_q  <= 1'b1;
          rdata_q <= dt[c_idx];
          if (cpu_we) dt[c_idx] <= cpu_wdata;
        end else begin
          busy <= 1'b1;
        end
      end
      if (gnt) begin
        if (bus_cmd == C_WB) begin
          st[c_idx] <= ST_I;
        end else begin
          tg[c_idx] <= c_tag;
          busy      <= 1'b0;
          done_q    <= 1'b1;
          if (bus_cmd == C_RD) begin
            dt[c_idx] <= bus_rdata;
            st[c_idx] <= ST_S;
            rdata_q   <= bus_rdata;
          end else begin
            dt[c_idx] <= cpu_wdata;
            st[c_idx] <= ST_M;
            rdata_q   <= cpu_wdata;
          end
        end
      end
    end
  end
endmodule

// File: rtl/msi_line_chk.sv
module msi_line_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_stall,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              flush_valid
);
  a_r2_fill_then_done: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd != 2'd3) |=> cpu_done);

  a_r10_wb_then_fill: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == 2'd3) |=> (bus_req && bus_cmd != 2'd3 && !cpu_done));

  a_r10_wb_victim_addr: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd == 2'd3) |->
      (bus_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0] && bus_addr != cpu_addr));

  a_r7_rd_flush_once: assert property (@(posedge clk) disable iff (rst)
    (flush_valid && snp_cmd == 2'd0) |=> !(flush_valid && snp_addr == $past(snp_addr)));

  a_r8_rdx_flush_once: assert property (@(posedge clk) disable iff (rst)
    (flush_valid && snp_cmd == 2'd1) |=> !(flush_valid && snp_addr == $past(snp_addr)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  a_r3_bus_wait_stalls: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> cpu_stall);

  a_r9_flush_needs_snoop: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (snp_valid && snp_cmd != 2'd2));
endmodule

bind msi_line_ctrl msi_line_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall),
  .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr), .snp_valid(snp_valid),
  .snp_cmd(snp_cmd), .snp_addr(snp_addr), .flush_valid(flush_valid)
);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;
  logic        clk = 0, rst = 1;
  logic        cpu_req = 0, cpu_we = 0;
  logic [7:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        cpu_stall, cpu_done, bus_req, flush_valid;
  logic [15:0] cpu_rdata, bus_wdata, flush_data, bus_rdata;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic        snp_valid = 0, hold = 0;
  logic [1:0]  snp_cmd = 0;
  logic [7:0]  snp_addr = 0;
  logic        bus_gnt;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] memv(input logic [7:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  assign bus_gnt   = bus_req && !hold;
  assign bus_rdata = memv(bus_addr);

  msi_line_ctrl u_dut (.*);

  typedef struct {
    int          kind;
    logic [1:0]  cmd;
    logic [7:0]  addr;
    logic [15:0] data;
    bit          chk;
    string       req;
  } item_t;
  item_t q[$];

  task automatic exp_bus(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d, input bit ck, input string r);
    item_t it; it.kind = 0; it.cmd = c; it.addr = a; it.data = d; it.chk = ck; it.req = r; q.push_back(it);
  endtask
  task automatic exp_flush(input logic [15:0] d, input string r);
    item_t it; it.kind = 1; it.cmd = 0; it.addr = 0; it.data = d; it.chk = 1; it.req = r; q.push_back(it);
  endtask
  task automatic exp_done(input logic [15:0] d, input bit ck, input string r);
    item_t it; it.kind = 2; it.cmd = 0; it.addr = 0; it.data = d; it.chk = ck; it.req = r; q.push_back(it);
  endtask

  task automatic compare(input int k, input logic [1:0] c, input logic [7:0] a, input logic [15:0] d);
    item_t e;
    tests++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event kind=%0d cmd=%0d addr=%h data=%h expected none", k, c, a, d);
      return;
    end
    e = q.pop_front();
    if (e.kind != k || (k == 0 && (e.cmd != c || e.addr != a)) || (e.chk && e.data != d)) begin
      fails++;
      $display("FAIL %s: got kind=%0d cmd=%0d addr=%h data=%h expected kind=%0d cmd=%0d addr=%h data=%h",
               e.req, k, c, a, d, e.kind, e.cmd, e.addr, e.data);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    if (bus_req && bus_gnt) compare(0, bus_cmd, bus_addr, bus_wdata);
    if (flush_valid)        compare(1, 2'd0, snp_addr, flush_data);
    if (cpu_done)           compare(2, 2'd0, 8'h00, cpu_rdata);
  end

  task automatic access(input bit we, input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_done);
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a);
    @(posedge clk); #1;
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  task automatic summary;
    if (q.size() != 0) begin
      tests++; fails++;
      $display("FAIL %s: %0d expected events missing, expected 0", q[0].req, q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired, got hang expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    tests++;
    if (bus_req || cpu_done || flush_valid) begin
      fails++;
      $display("FAIL R1: got req=%b done=%b flush=%b expected 000", bus_req, cpu_done, flush_valid);
    end

    exp_bus(0, 8'h10, 0, 0, "R1 R2"); exp_done(memv(8'h10), 1, "R2");
    access(0, 8'h10, 0);
    exp_done(memv(8'h10), 1, "R3");
    access(0, 8'h10, 0);
    exp_bus(2, 8'h10, 0, 0, "R5"); exp_done(0, 0, "R5");
    access(1, 8'h10, 16'h1111);
    exp_done(16'h1111, 1, "R3 R5");
    access(0, 8'h10, 0);
    exp_done(0, 0, "R6");
    access(1, 8'h10, 16'h2222);
    exp_flush(16'h2222, "R7");
    snoop(0, 8'h10);
    snoop(0, 8'h10);
    exp_done(16'h2222, 1, "R7");
    access(0, 8'h10, 0);
    exp_bus(2, 8'h10, 0, 0, "R7"); exp_done(0, 0, "R7");
    access(1, 8'h10, 16'h3333);

    exp_flush(16'h3333, "R8");
    snoop(1, 8'h10);
    exp_bus(0, 8'h10, 0, 0, "R8"); exp_done(memv(8'h10), 1, "R8");
    access(0, 8'h10, 0);

    snoop(0, 8'h10);
    exp_done(memv(8'h10), 1, "R9");
    access(0, 8'h10, 0);
    snoop(2, 8'h10);
    exp_bus(0, 8'h10, 0, 0, "R9"); exp_done(memv(8'h10), 1, "R9");
    access(0, 8'h10, 0);
    snoop(1, 8'h10);
    exp_bus(0, 8'h10, 0, 0, "R9"); exp_done(memv(8'h10), 1, "R9");
    access(0, 8'h10, 0);

    exp_bus(1, 8'h21, 0, 0, "R4"); exp_done(0, 0, "R4");
    access(1, 8'h21, 16'h4444);
    exp_done(16'h4444, 1, "R4");
    access(0, 8'h21, 0);
    exp_bus(3, 8'h21, 16'h4444, 1, "R10"); exp_bus(0, 8'h41, 0, 0, "R10");
    exp_done(memv(8'h41), 1, "R10");
    access(0, 8'h41, 0);
    exp_bus(0, 8'h81, 0, 0, "R10"); exp_done(memv(8'h81), 1, "R10");
    access(0, 8'h81, 0);

    exp_bus(0, 8'h12, 0, 0, "R11"); exp_done(memv(8'h12), 1, "R11");
    access(0, 8'h12, 0);
    hold = 1;
    exp_bus(1, 8'h12, 0, 0, "R11"); exp_done(0, 0, "R11");
    fork
      access(1, 8'h12, 16'h5555);
      begin
        repeat (3) @(posedge clk);
        snoop(2, 8'h12);
        #1 hold = 0;
      end
    join
    exp_done(16'h5555, 1, "R11");
    access(0, 8'h12, 0);

    exp_bus(1, 8'h13, 0, 0, "R12"); exp_done(0, 0, "R12");
    access(1, 8'h13, 16'h6666);
    exp_flush(16'h6666, "R12");
    snoop(0, 8'h13);

    repeat (3) @(posedge clk);
    summary();
  end
endmodule